// File: doc/BRIEF.md
# Halfword-to-Word Flash Fetch Adapter

This block sits on the read path between a 32-bit processor fetch port and a flash array that is only 16 bits wide. A processor read of 8, 16 or 32 bits arrives as a request with an address and a size code. The adapter decodes the address against the flash window and reads the array one halfword at a time. It returns the result zero-extended on a 32-bit data bus. A 32-bit read is built from two halfwords. The halfword at the even halfword address forms bits [15:0] and the next one forms bits [31:16].

The array is reached through two combinational halfword read slots. Slot B stands for the second access that the array can complete inside one core period when the core runs from a divided clock. When the clock-divider code is 0 the core runs at full speed. In that case only slot A is used, and a word read is split over two cycles. The ready output is low during the first cycle, while the lower halfword is held in a register. After a hard reset the flash also answers in the bottom of the address space. A one-cycle remap pulse removes that alias until the next reset.

Top module: `flash_fetch_adapter`

## Requirements
- R1: While reset is held and in the idle cycle after it, with no request, rsp_ready is 1, rsp_err is 0, rsp_data is 0 and neither array slot is enabled.
- R2: With a nonzero divider code, a word read (req_size 2'b10, and 2'b11 is treated as a word) completes in the request cycle with rsp_ready high. Its data is {array[odd], array[even]}, where even is the byte offset with bits [1:0] cleared, shifted right by one, and odd is even+1.
- R3: With divider code 0, a word read hitting the flash drives rsp_ready low in its first cycle. rsp_ready is high in the next cycle, which delivers the same {array[odd], array[even]} value. rsp_ready is never low for two cycles in a row.
- R4: With divider code 0, slot B is never enabled, so at most one array access happens per core cycle.
- R5: A halfword read (req_size 2'b01) completes in one cycle at any divider code. It returns {16'h0, array[offset>>1]}.
- R6: A byte read (req_size 2'b00) completes in one cycle at any divider code. It returns bits [7:0] of array[offset>>1] when address bit 0 is 0, and bits [15:8] when it is 1, zero-extended to 32 bits.
- R7: A word read ignores address bits [1:0].
- R8: Addresses from 0x0008_0000 to 0x0008_7FFF (the default 32 KiB window) hit the flash. The byte offset is the address's low 15 bits.
- R9: After reset, addresses 0x0000_0000 to 0x0000_7FFF also hit the flash with the same offset. A one-cycle pulse on remap_set removes this alias until the next reset, so low addresses then miss.
- R10: A request that misses the flash returns rsp_err 1, rsp_ready 1 and rsp_data 0 in the same cycle, with neither array slot enabled.
- R11: If a full-speed word read is withdrawn during its wait cycle, the half-finished read is discarded. The next word read again takes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low hard reset; re-enables the low alias |
| clk_div | input | 3 | Core clock-divider code; 0 means full speed |
| remap_set | input | 1 | One-cycle pulse that removes the low-address alias |
| req_valid | input | 1 | Read request present; held until rsp_ready |
| req_addr | input | 32 | Byte address of the read |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| rsp_ready | output | 1 | Read completes this cycle (low during a wait state) |
| rsp_err | output | 1 | Address outside the flash window |
| rsp_data | output | 32 | Read data, zero-extended, valid while rsp_ready is high |
| fl_en_a | output | 1 | Array slot A access enable |
| fl_addr_a | output | 14 | Array slot A halfword address |
| fl_rdata_a | input | 16 | Array slot A read data (combinational) |
| fl_en_b | output | 1 | Array slot B access enable (second in-period access) |
| fl_addr_b | output | 14 | Array slot B halfword address |
| fl_rdata_b | input | 16 | Array slot B read data (combinational) |

## Verification
Byte reads, halfword reads, misses and word reads with a nonzero divider code all return their result combinationally in the request cycle. The bench drives each request one nanosecond after a falling edge and samples one nanosecond later, before the next rising edge. A full-speed word read sees rsp_ready low in that first sample. Its data is due one rising edge later, so the bench waits for the next falling edge and samples again there. Remap and reset effects are checked on the first request issued after the edge that registered them.

// File: rtl/flash_fetch_pkg.sv
package flash_fetch_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } fetch_size_e;

    typedef struct packed {
        logic        phase;     // low halfword held, high halfword pending
        logic [15:0] low_hw;    // lower halfword of a split word read
        logic        alias_en;  // low-address alias of the flash active
    } fetch_state_t;

endpackage

// File: rtl/ffa_addr_decode.sv
module ffa_addr_decode #(
    parameter int          WIN_LOG2   = 15,
    parameter logic [31:0] FLASH_BASE = 32'h0008_0000
) (
    input  logic [31:0]         addr,
    input  logic                alias_en,
    output logic                hit,
    output logic [WIN_LOG2-1:0] offset
);
    localparam int TAG_W = 32 - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = FLASH_BASE[31:WIN_LOG2];

    logic phys_hit;
    logic low_hit;

    always_comb begin
        phys_hit = (addr[31:WIN_LOG2] == BASE_TAG);
        low_hit  = alias_en && (addr[31:WIN_LOG2] == '0);
        hit      = phys_hit || low_hit;
        offset   = addr[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/ffa_lane_select.sv
module ffa_lane_select
    import flash_fetch_pkg::*;
(
    input  logic [1:0]  size,
    input  logic        byte_sel,
    input  logic        use_held,
    input  logic [15:0] hw_a,
    input  logic [15:0] hw_b,
    input  logic [15:0] held_low,
    output logic [31:0] data
);
    localparam int LANES = 2;

    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = hw_a[8*g +: 8];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: data = {24'h0, lane[byte_sel]};
            SZ_HALF: data = {16'h0, hw_a};
            default: data = use_held ? {hw_a, held_low} : {hw_b, hw_a};
        endcase
    end
endmodule

// File: rtl/flash_fetch_adapter.sv
module flash_fetch_adapter
    import flash_fetch_pkg::*;
#(
    parameter int          WIN_LOG2   = 15,
    parameter logic [31:0] FLASH_BASE = 32'h0008_0000,
    parameter int          DIV_W      = 3,
    localparam int         HW_AW      = WIN_LOG2 - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             remap_set,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    input  logic [1:0]       req_size,
    output logic             rsp_ready,
    output logic             rsp_err,
    output logic [31:0]      rsp_data,
    output logic             fl_en_a,
    output logic [HW_AW-1:0] fl_addr_a,
    input  logic [15:0]      fl_rdata_a,
    output logic             fl_en_b,
    output logic [HW_AW-1:0] fl_addr_b,
    input  logic [15:0]      fl_rdata_b
);
    fetch_state_t state_q, state_d;

    logic                hit;
    logic [WIN_LOG2-1:0] offset;
    logic [HW_AW-1:0]    hw_idx, hw_even, hw_odd;
    logic                is_word, full_speed, access, need_wait, use_held;
    logic [31:0]         lane_data;

    ffa_addr_decode #(
        .WIN_LOG2   (WIN_LOG2),
        .FLASH_BASE (FLASH_BASE)
    ) u_decode (
        .addr     (req_addr),
        .alias_en (state_q.alias_en),
        .hit      (hit),
        .offset   (offset)
    );

    ffa_lane_select u_lanes (
        .size     (req_size),
        .byte_sel (offset[0]),
        .use_held (use_held),
        .hw_a     (fl_rdata_a),
        .hw_b     (fl_rdata_b),
        .held_low (state_q.low_hw),
        .data     (lane_data)
    );

    always_comb begin
        is_word    = req_size[1];
        full_speed = (clk_div == '0);
        access     = req_valid && hit;
        need_wait  = access && is_word && full_speed;
        use_held   = need_wait && state_q.phase;

        hw_idx  = offset[WIN_LOG2-1:1];
        hw_even = {hw_idx[HW_AW-1:1], 1'b0};
        hw_odd  = {hw_idx[HW_AW-1:1], 1'b1};

        fl_en_a   = access;
        fl_addr_a = !is_word ? hw_idx : (use_held ? hw_odd : hw_even);
        fl_en_b   = access && is_word && !full_speed;
        fl_addr_b = hw_odd;

        rsp_ready = !(need_wait && !state_q.phase);
        rsp_err   = req_valid && !hit;
        rsp_data  = (access && rsp_ready) ? lane_data : 32'h0;

        state_d          = state_q;
        state_d.phase    = need_wait && !state_q.phase;
        if (need_wait && !state_q.phase) begin
            state_d.low_hw = fl_rdata_a;
        end
        state_d.alias_en = state_q.alias_en && !remap_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: 1'b0, low_hw: 16'h0, alias_en: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    // R3: a wait state lasts exactly one cycle
    a_r3_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |=> rsp_ready);

    // R4: at full speed only one array access per core cycle
    a_r4_one_slot_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div == '0) |-> !fl_en_b);

    // R2: divided clock never inserts a wait state
    a_r2_divided_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && clk_div != '0) |-> rsp_ready);

    // R10: a miss answers at once and leaves the array idle
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ready && !fl_en_a && !fl_en_b && rsp_data == 32'h0));

    // R9: once removed, the alias stays removed until reset
    a_r9_alias_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.alias_en |=> !state_q.alias_en);
endmodule

// File: tb/tb_flash_fetch_adapter.sv
module tb_flash_fetch_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_div = 3'd1;
    logic        remap_set = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic [1:0]  req_size = 2'b00;
    logic        rsp_ready, rsp_err;
    logic [31:0] rsp_data;
    logic        fl_en_a, fl_en_b;
    logic [13:0] fl_addr_a, fl_addr_b;
    logic [15:0] fl_rdata_a, fl_rdata_b;

    int checks = 0;
    int failures = 0;
    bit alias_on = 1'b1;

    always #4 clk = ~clk;

    function automatic logic [15:0] mem_hw(input logic [13:0] hw);
        logic [15:0] x;
        x = {2'b01, hw} * 16'd40503;
        return x ^ 16'h3C5A;
    endfunction

    assign fl_rdata_a = mem_hw(fl_addr_a);
    assign fl_rdata_b = mem_hw(fl_addr_b);

    flash_fetch_adapter dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .remap_set(remap_set),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .fl_en_a(fl_en_a), .fl_addr_a(fl_addr_a), .fl_rdata_a(fl_rdata_a),
        .fl_en_b(fl_en_b), .fl_addr_b(fl_addr_b), .fl_rdata_b(fl_rdata_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [31:0] a);
        return (a[31:15] == 17'h00010) || (alias_on && a[31:15] == 17'h0);
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz);
        logic [13:0] hw;
        logic [15:0] v;
        hw = a[14:1];
        if (!exp_hit(a)) return 32'h0;
        if (sz[1]) return {mem_hw({hw[13:1], 1'b1}), mem_hw({hw[13:1], 1'b0})};
        v = mem_hw(hw);
        if (sz == 2'b01) return {16'h0, v};
        return {24'h0, a[0] ? v[15:8] : v[7:0]};
    endfunction

    // One read; returns after the completing sample, one ns past a falling edge.
    task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] dv,
                           input string req);
        bit wait_due;
        wait_due = exp_hit(a) && sz[1] && (dv == 3'd0);
        @(negedge clk);
        #1;
        req_valid = 1'b1; req_addr = a; req_size = sz; clk_div = dv;
        #1;
        if (dv == 3'd0) chk({req, " R4 slot B idle"}, {31'h0, fl_en_b}, 32'h0);
        if (wait_due) begin
            chk({req, " R3 wait cycle"}, {31'h0, rsp_ready}, 32'h0);
            @(negedge clk);
            #2;
        end
        chk({req, " ready"}, {31'h0, rsp_ready}, 32'h1);
        chk({req, " R10 err"}, {31'h0, rsp_err}, {31'h0, !exp_hit(a)});
        chk({req, " data"}, rsp_data, exp_data(a, sz));
        if (!exp_hit(a)) chk({req, " R10 no access"}, {30'h0, fl_en_a, fl_en_b}, 32'h0);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        alias_on = 1'b1;
        #1;
        chk("R1 ready in reset", {31'h0, rsp_ready}, 32'h1);
        chk("R1 idle outputs in reset", {rsp_data[29:0], rsp_err, fl_en_a}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 idle after reset", {rsp_data[28:0], rsp_err, fl_en_a, !rsp_ready}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        pulse_reset();

        // Directed corners
        do_read(32'h0008_0100, 2'b10, 3'd2, "R2 word divided");
        do_read(32'h0008_0103, 2'b11, 3'd5, "R7 word alt size unaligned");
        do_read(32'h0008_0100, 2'b10, 3'd0, "R3 word full speed");
        do_read(32'h0008_7FFE, 2'b10, 3'd0, "R8 top of window word");
        do_read(32'h0008_0102, 2'b01, 3'd0, "R5 half full speed");
        do_read(32'h0008_0105, 2'b00, 3'd0, "R6 byte odd lane");
        do_read(32'h0008_0104, 2'b00, 3'd7, "R6 byte even lane");
        do_read(32'h0000_0100, 2'b10, 3'd3, "R9 alias word");
        do_read(32'h0008_8000, 2'b10, 3'd1, "R8 R10 just above window");
        do_read(32'h0007_FFFC, 2'b01, 3'd0, "R10 just below window");

        // R11: withdraw a full-speed word read in its wait cycle
        @(negedge clk);
        #1;
        req_valid = 1'b1; req_addr = 32'h0008_0200; req_size = 2'b10; clk_div = 3'd0;
        #1;
        chk("R11 first wait", {31'h0, rsp_ready}, 32'h0);
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        #1;
        chk("R11 idle after withdraw", {31'h0, rsp_ready}, 32'h1);
        do_read(32'h0008_0300, 2'b10, 3'd0, "R11 fresh word after withdraw");

        // Random, alias active
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a;
            int reg_sel;
            reg_sel = $urandom % 4;
            a = (reg_sel < 2) ? (32'h0008_0000 | ($urandom & 32'h7FFF)) :
                (reg_sel == 2) ? ($urandom & 32'h7FFF) : ($urandom | 32'h0100_0000);
            do_read(a, 2'($urandom), 3'($urandom), "R2 R5 R6 random");
        end

        // R9: remap removes the alias
        @(negedge clk);
        req_valid = 1'b0;
        remap_set = 1'b1;
        @(negedge clk);
        remap_set = 1'b0;
        alias_on = 1'b0;
        do_read(32'h0000_0100, 2'b10, 3'd2, "R9 low address after remap");
        do_read(32'h0008_0100, 2'b10, 3'd2, "R9 window after remap");

        for (int i = 0; i < 200; i++) begin
            logic [31:0] a;
            a = ($urandom % 2 == 0) ? (32'h0008_0000 | ($urandom & 32'h7FFF)) : ($urandom & 32'h7FFF);
            do_read(a, 2'($urandom), 3'($urandom), "R9 random after remap");
        end

        // R1 R9: reset brings the alias back
        pulse_reset();
        do_read(32'h0000_0204, 2'b01, 3'd0, "R9 alias restored by reset");

        @(negedge clk);
        req_valid = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule